// File: doc/BRIEF.md
# Bipolar Line Encoder with Selectable B8ZS / HDB3 Zero Substitution

This block is the digital transmit data path of a primary-rate (T1 or E1) line interface. Each clock cycle it captures one bit on the falling clock edge. The bit comes from either the primary dual-rail data pair or the loopback dual-rail data pair, as chosen by a select input. A mark is a high level on either rail of the chosen pair. An alarm input overrides the data and forces a mark in every bit period. The captured symbols enter a fixed eight-stage delay line. While a run of zeros sits inside that line, the substitution logic rewrites it into a code word: B8ZS when the rate select is low (T1), or HDB3 when it is high (E1). With the suppression enable low, no rewriting takes place.

A four-state polarity machine turns the symbols at the head of the line into one-cycle positive and negative pulse commands. The state pairs the polarity of the last pulse with the parity of the pulses sent since the last violation. The states are `ST_NEG_EVEN`, `ST_NEG_ODD`, `ST_POS_EVEN` and `ST_POS_ODD`. There are three kinds of transition. An alternating transition (on a mark or a bipolar-rule pulse) flips both the polarity and the parity. A violation transition keeps the polarity and clears the parity to even. A hold transition (on a space or an idle slot) leaves the state as it is. After reset the delay line holds idle slots, which never count as zeros, so the outputs stay quiet until the first captured bit reaches them.

Top module: `line_encoder_zcs`

## Requirements
- R1: Data is captured on the falling clock edge. With `lb_sel` low the primary pair `pri_pos`/`pri_neg` is used and the loopback pair is ignored. With `lb_sel` high the loopback pair `lb_pos`/`lb_neg` is used and the primary pair is ignored.
- R2: A bit is a mark when either rail of the selected pair is high. This holds for dual-rail input, where one rail carries each mark, and for single-rail NRZ input, where both rails carry the same level.
- R3: While `alarm_ones` is high at a falling edge, that bit is a mark whatever the data inputs carry.
- R4: A bit captured at the falling edge after rising edge n drives the outputs from rising edge n+9 until rising edge n+10. This latency is the same in every mode.
- R5: A mark gives a pulse whose polarity is opposite to the previous pulse (AMI). A zero gives no pulse. `pulse_pos` and `pulse_neg` are never high together.
- R6: With `zcs_en` low, runs of zeros of any length pass through without substitution.
- R7: With `zcs_en` high and `rate_e1` low, each run of eight zeros is sent as 000VB0VB. Here V repeats the polarity of the pulse before it, and B takes the opposite polarity.
- R8: With `zcs_en` high and `rate_e1` high, each run of four zeros is sent as 000V when an odd number of pulses has been sent since the last V, and as B00V when that number is even. V repeats the polarity of the pulse before it.
- R9: During reset both outputs are low. After reset the last polarity counts as negative, so the first mark is positive, and the pulse parity counts as even.
- R10: After reset, the outputs stay low until the first captured bit reaches them, and the idle slots ahead of it never trigger a substitution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; capture on falling edge, line and outputs on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_pos | input | 1 | Primary data, positive rail |
| pri_neg | input | 1 | Primary data, negative rail |
| lb_pos | input | 1 | Loopback data, positive rail |
| lb_neg | input | 1 | Loopback data, negative rail |
| lb_sel | input | 1 | High selects the loopback pair |
| alarm_ones | input | 1 | High forces a mark in every bit |
| zcs_en | input | 1 | High enables zero substitution |
| rate_e1 | input | 1 | Low selects B8ZS (T1), high selects HDB3 (E1) |
| pulse_pos | output | 1 | One-cycle positive pulse command |
| pulse_neg | output | 1 | One-cycle negative pulse command |

## Verification
The alarm override and zero substitution can act in the same cycle. An alarm window can open while a long zero run is still being captured, so the zero run is cut short before it fills a code-word window. The bench provokes this by opening alarm windows in the middle of random zero runs, in both B8ZS and HDB3 modes. It judges every output cycle against an independent stream model that applies the alarm before the substitution rules. A second overlap is a switch of the source select in the middle of a zero run. Here the run must continue across the switch only when the newly selected port also carries zeros.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    // Symbol held in each slot of the delay line.
    typedef enum logic [2:0] {
        SYM_IDLE  = 3'd0,   // slot not yet filled after reset
        SYM_SPACE = 3'd1,   // zero, no pulse
        SYM_MARK  = 3'd2,   // data one, alternate polarity
        SYM_BIP   = 3'd3,   // inserted pulse obeying alternation
        SYM_VIOL  = 3'd4    // inserted pulse repeating last polarity
    } sym_t;

    // Polarity of the last pulse combined with pulse parity since last V.
    typedef enum logic [1:0] {
        ST_NEG_EVEN = 2'd0,
        ST_NEG_ODD  = 2'd1,
        ST_POS_EVEN = 2'd2,
        ST_POS_ODD  = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        ZM_PLAIN = 2'd0,
        ZM_B8ZS  = 2'd1,
        ZM_HDB3  = 2'd2
    } zmode_t;

endpackage

// File: rtl/lenc_capture.sv
module lenc_capture
    import lenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pri_pos_i,
    input  logic pri_neg_i,
    input  logic lb_pos_i,
    input  logic lb_neg_i,
    input  logic lb_sel_i,
    input  logic alarm_i,
    output sym_t cap_o
);

    logic src_mark;
    sym_t cap_q;

    // Either rail high means a mark; covers dual-rail and NRZ use.
    always_comb begin
        if (lb_sel_i) begin
            src_mark = lb_pos_i | lb_neg_i;
        end else begin
            src_mark = pri_pos_i | pri_neg_i;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= SYM_IDLE;
        end else if (alarm_i || src_mark) begin
            cap_q <= SYM_MARK;
        end else begin
            cap_q <= SYM_SPACE;
        end
    end

    assign cap_o = cap_q;

    assert_alarm_forces_mark_R3: assert property (
        @(negedge clk) disable iff (!rst_n)
        alarm_i |=> (cap_q == SYM_MARK));

    assert_loopback_source_R1: assert property (
        @(negedge clk) disable iff (!rst_n)
        (!alarm_i && lb_sel_i) |=>
            (cap_q == ($past(lb_pos_i | lb_neg_i) ? SYM_MARK : SYM_SPACE)));

    assert_primary_source_R1: assert property (
        @(negedge clk) disable iff (!rst_n)
        (!alarm_i && !lb_sel_i) |=>
            (cap_q == ($past(pri_pos_i | pri_neg_i) ? SYM_MARK : SYM_SPACE)));

endmodule

// File: rtl/lenc_subst.sv
module lenc_subst
    import lenc_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LONG_RUN  = 8,
    parameter int SHORT_RUN = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  sym_t   tail_i,
    input  zmode_t mode_i,
    input  logic   parity_odd_i,
    output sym_t   head_o
);

    // Positions inside the long code word 000VB0VB.
    localparam int L_V1 = LONG_RUN - 5;
    localparam int L_B1 = LONG_RUN - 4;
    localparam int L_V2 = LONG_RUN - 2;
    localparam int L_B2 = LONG_RUN - 1;
    // Position of the violation inside the short code word.
    localparam int S_V  = SHORT_RUN - 1;

    sym_t               line_q [DEPTH];
    sym_t               cur    [DEPTH];
    logic [DEPTH-1:0]   is_space;
    logic               long_hit;
    logic               short_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_space
        assign is_space[g] = (line_q[g] == SYM_SPACE);
    end

    assign long_hit  = &is_space[LONG_RUN-1:0];
    assign short_hit = &is_space[SHORT_RUN-1:0];

    // Rewrite a zero run in place once its first zero reaches the head.
    always_comb begin
        cur = line_q;
        unique case (mode_i)
            ZM_B8ZS: begin
                if (long_hit) begin
                    cur[L_V1] = SYM_VIOL;
                    cur[L_B1] = SYM_BIP;
                    cur[L_V2] = SYM_VIOL;
                    cur[L_B2] = SYM_BIP;
                end
            end
            ZM_HDB3: begin
                if (short_hit) begin
                    cur[S_V] = SYM_VIOL;
                    if (!parity_odd_i) begin
                        cur[0] = SYM_BIP;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    assign head_o = cur[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= SYM_IDLE;
            end
        end else begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                line_q[i] <= cur[i+1];
            end
            line_q[DEPTH-1] <= tail_i;
        end
    end

    assert_long_word_placed_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode_i == ZM_B8ZS && long_hit) |=>
            (line_q[L_V1-1] == SYM_VIOL && line_q[L_B2-1] == SYM_BIP));

    assert_short_word_placed_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode_i == ZM_HDB3 && short_hit) |=> (line_q[S_V-1] == SYM_VIOL));

    assert_plain_untouched_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode_i == ZM_PLAIN) |-> (head_o == line_q[0]));

endmodule

// File: rtl/lenc_polarity.sv
module lenc_polarity
    import lenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t head_i,
    output logic parity_odd_o,
    output logic pos_o,
    output logic neg_o
);

    line_st_t state_q;
    line_st_t state_d;
    logic     alt;
    logic     viol;
    logic     last_pos;

    assign alt      = (head_i == SYM_MARK) || (head_i == SYM_BIP);
    assign viol     = (head_i == SYM_VIOL);
    assign last_pos = (state_q == ST_POS_EVEN) || (state_q == ST_POS_ODD);
    assign parity_odd_o = (state_q == ST_NEG_ODD) || (state_q == ST_POS_ODD);

    // Next-state: alternate, violation or hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NEG_EVEN: begin
                if (alt)       state_d = ST_POS_ODD;
                else if (viol) state_d = ST_NEG_EVEN;
            end
            ST_NEG_ODD: begin
                if (alt)       state_d = ST_POS_EVEN;
                else if (viol) state_d = ST_NEG_EVEN;
            end
            ST_POS_EVEN: begin
                if (alt)       state_d = ST_NEG_ODD;
                else if (viol) state_d = ST_POS_EVEN;
            end
            ST_POS_ODD: begin
                if (alt)       state_d = ST_NEG_EVEN;
                else if (viol) state_d = ST_POS_EVEN;
            end
            default: state_d = ST_NEG_EVEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NEG_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_o <= 1'b0;
            neg_o <= 1'b0;
        end else begin
            pos_o <= (alt && !last_pos) || (viol && last_pos);
            neg_o <= (alt && last_pos) || (viol && !last_pos);
        end
    end

    assert_single_rail_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0({pos_o, neg_o}));

    assert_space_silent_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (head_i == SYM_SPACE || head_i == SYM_IDLE) |=> (!pos_o && !neg_o));

    assert_viol_clears_parity_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        viol |=> !parity_odd_o);

    assert_pulse_on_symbol_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (alt || viol) |=> (pos_o || neg_o));

endmodule

// File: rtl/line_encoder_zcs.sv
module line_encoder_zcs
    import lenc_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LONG_RUN  = 8,
    parameter int SHORT_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_pos,
    input  logic pri_neg,
    input  logic lb_pos,
    input  logic lb_neg,
    input  logic lb_sel,
    input  logic alarm_ones,
    input  logic zcs_en,
    input  logic rate_e1,
    output logic pulse_pos,
    output logic pulse_neg
);

    sym_t   cap_sym;
    sym_t   head_sym;
    zmode_t mode;
    logic   parity_odd;

    always_comb begin
        if (!zcs_en) begin
            mode = ZM_PLAIN;
        end else if (rate_e1) begin
            mode = ZM_HDB3;
        end else begin
            mode = ZM_B8ZS;
        end
    end

    lenc_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pri_pos_i (pri_pos),
        .pri_neg_i (pri_neg),
        .lb_pos_i  (lb_pos),
        .lb_neg_i  (lb_neg),
        .lb_sel_i  (lb_sel),
        .alarm_i   (alarm_ones),
        .cap_o     (cap_sym)
    );

    lenc_subst #(
        .DEPTH     (DEPTH),
        .LONG_RUN  (LONG_RUN),
        .SHORT_RUN (SHORT_RUN)
    ) u_subst (
        .clk          (clk),
        .rst_n        (rst_n),
        .tail_i       (cap_sym),
        .mode_i       (mode),
        .parity_odd_i (parity_odd),
        .head_o       (head_sym)
    );

    lenc_polarity u_polarity (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_i       (head_sym),
        .parity_odd_o (parity_odd),
        .pos_o        (pulse_pos),
        .neg_o        (pulse_neg)
    );

    assert_reset_quiet_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pulse_pos && !pulse_neg));

endmodule

// File: tb/line_encoder_zcs_bench.sv
module line_encoder_zcs_bench;

    localparam int MAXN = 400;
    localparam int LAT  = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, pri_pos, pri_neg, lb_pos, lb_neg, lb_sel, alarm_ones, zcs_en, rate_e1;
    logic pulse_pos, pulse_neg;

    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'h1234_5678;

    logic d_pp [MAXN];
    logic d_pn [MAXN];
    logic d_lp [MAXN];
    logic d_ln [MAXN];
    logic d_sel[MAXN];
    logic d_al [MAXN];
    logic eff  [MAXN];
    logic e_pos[MAXN];
    logic e_neg[MAXN];

    line_encoder_zcs u_line_encoder_zcs (
        .clk(clk), .rst_n(rst_n),
        .pri_pos(pri_pos), .pri_neg(pri_neg),
        .lb_pos(lb_pos), .lb_neg(lb_neg), .lb_sel(lb_sel),
        .alarm_ones(alarm_ones), .zcs_en(zcs_en), .rate_e1(rate_e1),
        .pulse_pos(pulse_pos), .pulse_neg(pulse_neg)
    );

    task automatic check(input logic ep, input logic en, input string tag, input int idx);
        checks++;
        if (pulse_pos !== ep || pulse_neg !== en) begin
            errors++;
            $display("FAIL %s bit %0d got pos=%b neg=%b expected pos=%b neg=%b",
                     tag, idx, pulse_pos, pulse_neg, ep, en);
        end
    endtask

    // src: 0 primary, 1 loopback, 2 switching every 13 bits.
    task automatic gen(input int len, input int zmax, input int first_zeros,
                       input int src, input bit nrz, input bit alarm_win);
        int  zl;
        bit  raw, p, n;
        zl = first_zeros;
        for (int i = 0; i < len; i++) begin
            if (zl > 0) begin
                raw = 1'b0;
                zl--;
            end else begin
                raw = 1'b1;
                seed = seed * 32'd1103515245 + 32'd12345;
                zl = int'((seed >> 16) % (zmax + 1));
            end
            d_sel[i] = (src == 0) ? 1'b0 : (src == 1) ? 1'b1 : 1'(((i / 13) % 2) == 1);
            d_al[i]  = alarm_win && ((i / 20) % 3 == 1);
            p = raw && (nrz || (i % 2 == 0));
            n = raw && (nrz || (i % 2 == 1));
            if (d_sel[i]) begin
                d_lp[i] = p;    d_ln[i] = n;
                d_pp[i] = !raw; d_pn[i] = !raw;
            end else begin
                d_pp[i] = p;    d_pn[i] = n;
                d_lp[i] = !raw; d_ln[i] = !raw;
            end
            eff[i] = d_al[i] | raw;
        end
    endtask

    // Independent stream model of the pulse commands.
    task automatic model(input int len, input bit zcs, input bit e1);
        bit last_pos, odd, allz;
        int i;
        last_pos = 1'b0;
        odd = 1'b0;
        for (int k = 0; k < len; k++) begin
            e_pos[k] = 1'b0;
            e_neg[k] = 1'b0;
        end
        i = 0;
        while (i < len) begin
            allz = 1'b0;
            if (zcs && !e1 && i + 7 < len) begin
                allz = 1'b1;
                for (int k = 0; k < 8; k++) if (eff[i+k]) allz = 1'b0;
            end
            if (allz) begin
                e_pos[i+3] = last_pos;  e_neg[i+3] = !last_pos;
                last_pos = !last_pos;
                e_pos[i+4] = last_pos;  e_neg[i+4] = !last_pos;
                e_pos[i+6] = last_pos;  e_neg[i+6] = !last_pos;
                last_pos = !last_pos;
                e_pos[i+7] = last_pos;  e_neg[i+7] = !last_pos;
                odd = 1'b1;
                i += 8;
            end else begin
                if (zcs && e1 && i + 3 < len) begin
                    allz = 1'b1;
                    for (int k = 0; k < 4; k++) if (eff[i+k]) allz = 1'b0;
                end
                if (allz) begin
                    if (!odd) begin
                        last_pos = !last_pos;
                        e_pos[i] = last_pos; e_neg[i] = !last_pos;
                    end
                    e_pos[i+3] = last_pos; e_neg[i+3] = !last_pos;
                    odd = 1'b0;
                    i += 4;
                end else begin
                    if (eff[i]) begin
                        last_pos = !last_pos;
                        e_pos[i] = last_pos; e_neg[i] = !last_pos;
                        odd = !odd;
                    end
                    i++;
                end
            end
        end
    endtask

    task automatic run(input int len, input bit zcs, input bit e1, input string tag);
        int j;
        zcs_en = zcs; rate_e1 = e1;
        rst_n = 1'b0;
        pri_pos = 0; pri_neg = 0; lb_pos = 0; lb_neg = 0; lb_sel = 0; alarm_ones = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(1'b0, 1'b0, "R9 outputs low in reset", -1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (i > 0) begin
                @(posedge clk); #1;
            end
            pri_pos = d_pp[i]; pri_neg = d_pn[i];
            lb_pos = d_lp[i];  lb_neg = d_ln[i];
            lb_sel = d_sel[i]; alarm_ones = d_al[i];
            @(negedge clk); #1;
            j = i - LAT;
            if (j < 0) check(1'b0, 1'b0, "R10 idle fill after reset", j);
            else       check(e_pos[j], e_neg[j], tag, j);
        end
    endtask

    task automatic t_reset_idle();
        gen(40, 3, 0, 0, 1'b0, 1'b0); model(40, 1'b1, 1'b0);
        run(40, 1'b1, 1'b0, "R9 first mark positive");
    endtask

    task automatic t_ami_primary();
        gen(200, 2, 0, 0, 1'b0, 1'b0); model(200, 1'b0, 1'b0);
        run(200, 1'b0, 1'b0, "R5 R4 AMI dual-rail primary");
    endtask

    task automatic t_nrz();
        gen(200, 3, 0, 0, 1'b1, 1'b0); model(200, 1'b1, 1'b1);
        run(200, 1'b1, 1'b1, "R2 NRZ single-rail input");
    endtask

    task automatic t_loopback();
        gen(200, 5, 0, 1, 1'b0, 1'b0); model(200, 1'b0, 1'b0);
        run(200, 1'b0, 1'b0, "R1 loopback port");
        gen(260, 9, 0, 2, 1'b0, 1'b0); model(260, 1'b1, 1'b0);
        run(260, 1'b1, 1'b0, "R1 source switch mid run");
    endtask

    task automatic t_transparent();
        gen(300, 17, 12, 0, 1'b0, 1'b0); model(300, 1'b0, 1'b0);
        run(300, 1'b0, 1'b0, "R6 transparent long zeros");
    endtask

    task automatic t_b8zs();
        gen(360, 17, 8, 0, 1'b0, 1'b0); model(360, 1'b1, 1'b0);
        run(360, 1'b1, 1'b0, "R7 B8ZS substitution");
    endtask

    task automatic t_hdb3();
        gen(360, 9, 4, 0, 1'b0, 1'b0); model(360, 1'b1, 1'b1);
        run(360, 1'b1, 1'b1, "R8 HDB3 substitution");
    endtask

    task automatic t_alarm();
        gen(240, 12, 0, 0, 1'b0, 1'b1); model(240, 1'b0, 1'b0);
        run(240, 1'b0, 1'b0, "R3 alarm all ones");
        gen(300, 12, 6, 2, 1'b0, 1'b1); model(300, 1'b1, 1'b0);
        run(300, 1'b1, 1'b0, "R3 R7 alarm during B8ZS run");
        gen(300, 9, 2, 0, 1'b1, 1'b1); model(300, 1'b1, 1'b1);
        run(300, 1'b1, 1'b1, "R3 R8 alarm during HDB3 run");
    endtask

    initial begin
        #(200_000 * 10);
        errors++;
        checks++;
        $display("FAIL R4 watchdog expired got running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_ami_primary();
        t_nrz();
        t_loopback();
        t_transparent();
        t_b8zs();
        t_hdb3();
        t_alarm();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule